// File: doc/BRIEF.md
# Complementary PWM Group Generator

The block produces four active-high PWM outputs for one switching group, organised as two channels (A and B), each with a high-side and a low-side output. One counter sets the timing for the whole group. It runs in edge-aligned or center-aligned form, as a single control bit selects. Each output is active while the counter value is below that output's duty value.

In paired operation, each channel's low side is the complement of its high side. A programmable dead time delays the rising edge of both outputs, so the two outputs of a pair are never on together and a guard gap always separates them. In independent operation, all four outputs compare against their own duty registers and no dead time is applied. Each output has its own disable bit. A run bit starts and stops the whole group.

Software reaches the block through a plain write port. Period, dead time, duties and the two mode bits go into staging registers. These values move into the active set only at a PWM cycle boundary, or at any time while the group is stopped. The run bit and the disable bits act at once. The data width must be at least 8 bits.

Top module: `pwm_group`

## Requirements
- R1: After reset, and in every clock after a cycle in which the run bit (control bit 0) is clear, all four outputs are low.
- R2: In edge-aligned mode (control bit 1 = 0), the counter steps 0,1,…,P-1 and then wraps, so one PWM cycle lasts P clocks. A high side with duty D is high for D clocks of each cycle. The first count of the first cycle follows the run-bit write by one clock and reaches the outputs two clocks later.
- R3: In center-aligned mode (control bit 1 = 1), the counter steps up 0…P-1 and then down P-1…0, so one cycle lasts 2P clocks. An output with duty D is high for 2D clocks, centred on the turning point.
- R4: A duty of P or more holds its output high for the whole cycle, and a duty of 0 holds it low.
- R5: In paired mode (control bit 2 = 0), the low side of a channel is on while the high-side compare is off. The rising edge of each output of the pair comes dead-time (DT) clocks after the compare changes, and falling edges are not delayed. In steady state, a channel with duty D, DT < D and DT < P-D has its high side on for D-DT clocks and its low side on for P-D-DT clocks of each edge-aligned cycle.
- R6: In paired mode, the high and low outputs of a channel are never high together. Before either one rises, both have been low for at least DT clocks.
- R7: In independent mode (control bit 2 = 1), each of the four outputs compares the counter with its own duty register and has no dead time.
- R8: Control bits 4, 5, 6 and 7 disable outputs AH, AL, BH and BL respectively. A disabled output is low from the next clock on, and the other outputs are unaffected.
- R9: Period, dead time, the four duties and the two mode bits written while the group runs take effect at the first clock of the next PWM cycle. While the group is stopped, they take effect for the first cycle after the run bit is set.
- R10: The write addresses are 0 control, 1 period, 2 dead time, 3 duty AH, 4 duty BH, 5 duty AL and 6 duty BL. Address 7 is ignored.
- R11: A period value of 0 acts as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| pwm_ah_o | output | 1 | Channel A high-side output |
| pwm_al_o | output | 1 | Channel A low-side output |
| pwm_bh_o | output | 1 | Channel B high-side output |
| pwm_bl_o | output | 1 | Channel B low-side output |

## Verification
Four properties are checked on every clock:
- Outputs are masked when the group is stopped or an output is disabled.
- The two outputs of a pair never overlap in paired mode.
- The gap before any paired rising edge is at least the active dead time.
- The counter stays inside the active period, and the active period changes only at a counter boundary.

The saturated and zero duties, the exact high-time counts in both counting modes, and the deferral of mid-cycle writes to the next cycle can only be shown by the bench's scenarios. The bench compares every output on every clock against an expected waveform that it builds from the register values it has written.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_OUT = 4;
  localparam int unsigned NUM_CH  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_PERIOD  = 3'd1,
    REG_DEAD    = 3'd2,
    REG_DUTY_AH = 3'd3,
    REG_DUTY_BH = 3'd4,
    REG_DUTY_AL = 3'd5,
    REG_DUTY_BL = 3'd6
  } reg_addr_e;

  // control bit positions
  localparam int unsigned CTRL_RUN    = 0;
  localparam int unsigned CTRL_CENTER = 1;
  localparam int unsigned CTRL_INDEP  = 2;
  localparam int unsigned CTRL_DIS    = 4;
  localparam int unsigned CTRL_W      = 8;

  // output index: 0 AH, 1 AL, 2 BH, 3 BL
  function automatic logic [ADDR_W-1:0] duty_addr(input int unsigned idx);
    case (idx)
      0:       return REG_DUTY_AH;
      1:       return REG_DUTY_AL;
      2:       return REG_DUTY_BH;
      default: return REG_DUTY_BL;
    endcase
  endfunction
endpackage

// File: rtl/pwm_grp_regs.sv
module pwm_grp_regs
  import pwm_grp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [CNT_W-1:0]                  wr_data_i,
  input  logic                              load_i,
  output logic                              run_o,
  output logic [NUM_OUT-1:0]                dis_o,
  output logic                              center_o,
  output logic                              indep_o,
  output logic [CNT_W-1:0]                  per_o,
  output logic [CNT_W-1:0]                  dead_o,
  output logic [NUM_OUT-1:0][CNT_W-1:0]     duty_o
);
  logic [CTRL_W-1:0]            ctrl_q;
  logic [CNT_W-1:0]             stg_per_q, stg_dead_q;
  logic [NUM_OUT-1:0][CNT_W-1:0] stg_duty_q;
  logic [CNT_W-1:0]             per_eff;
  logic                         ctrl_unused;

  assign ctrl_unused = ^{wr_data_i[CNT_W-1:CTRL_W], ctrl_q[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      stg_per_q  <= '0;
      stg_dead_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_CTRL:   ctrl_q     <= wr_data_i[CTRL_W-1:0];
        REG_PERIOD: stg_per_q  <= wr_data_i;
        REG_DEAD:   stg_dead_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_duty
    localparam logic [ADDR_W-1:0] DutyAddr = duty_addr(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             stg_duty_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == DutyAddr) stg_duty_q[g] <= wr_data_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     duty_o[g] <= '0;
      else if (load_i) duty_o[g] <= stg_duty_q[g];
    end
  end

  // zero period runs as one clock
  assign per_eff = (stg_per_q == '0) ? CNT_W'(1) : stg_per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o    <= CNT_W'(1);
      dead_o   <= '0;
      center_o <= 1'b0;
      indep_o  <= 1'b0;
    end else if (load_i) begin
      per_o    <= per_eff;
      dead_o   <= stg_dead_q;
      center_o <= ctrl_q[CTRL_CENTER];
      indep_o  <= ctrl_q[CTRL_INDEP];
    end
  end

  assign run_o = ctrl_q[CTRL_RUN];
  assign dis_o = ctrl_q[CTRL_DIS +: NUM_OUT];
endmodule

// File: rtl/pwm_grp_counter.sv
module pwm_grp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, top;
  logic             down_q;

  assign top    = per_i - CNT_W'(1);
  assign wrap_o = center_i ? (down_q && cnt_q == '0) : (cnt_q >= top);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (center_i) begin
      // each turning value is held for two clocks
      if (!down_q) begin
        if (cnt_q >= top) down_q <= 1'b1;
        else              cnt_q  <= cnt_q + CNT_W'(1);
      end else begin
        if (cnt_q == '0) down_q <= 1'b0;
        else             cnt_q  <= cnt_q - CNT_W'(1);
      end
    end else begin
      down_q <= 1'b0;
      cnt_q  <= wrap_o ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_grp_deadband.sv
module pwm_grp_deadband #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ref_i,
  input  logic [CNT_W-1:0] dead_i,
  output logic             hi_o,
  output logic             lo_o
);
  localparam int unsigned RunW = CNT_W + 1;

  logic            ref_q;
  logic [RunW-1:0] run_q;  // clocks ref_q has held its level
  logic            settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      run_q <= '0;
    end else if (clr_i) begin
      ref_q <= 1'b0;
      run_q <= '0;
    end else if (ref_i != ref_q) begin
      ref_q <= ref_i;
      run_q <= RunW'(1);
    end else if (run_q != '1) begin
      run_q <= run_q + RunW'(1);
    end
  end

  assign settled = run_q > {1'b0, dead_i};
  assign hi_o    =  ref_q && settled;
  assign lo_o    = !ref_q && settled;
endmodule

// File: rtl/pwm_group.sv
module pwm_group
  import pwm_grp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_ah_o,
  output logic             pwm_al_o,
  output logic             pwm_bh_o,
  output logic             pwm_bl_o
);
  logic                          run, center_act, indep_act, wrap, load;
  logic [NUM_OUT-1:0]            dis, cmp, np_q, paired, core, out_q;
  logic [CNT_W-1:0]              per_act, dead_act, cnt;
  logic [NUM_OUT-1:0][CNT_W-1:0] duty_act;

  assign load = !run || wrap;

  pwm_grp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .run_o     (run),
    .dis_o     (dis),
    .center_o  (center_act),
    .indep_o   (indep_act),
    .per_o     (per_act),
    .dead_o    (dead_act),
    .duty_o    (duty_act)
  );

  pwm_grp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .center_i (center_act),
    .per_i    (per_act),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cmp
    assign cmp[g] = cnt < duty_act[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   np_q[g] <= 1'b0;
      else if (!run) np_q[g] <= 1'b0;
      else           np_q[g] <= cmp[g];
    end
  end

  // paired channels follow the high-side compare of each channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_pair
    pwm_grp_deadband #(.CNT_W(CNT_W)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!run),
      .ref_i  (cmp[2*c]),
      .dead_i (dead_act),
      .hi_o   (paired[2*c]),
      .lo_o   (paired[2*c+1])
    );
  end

  assign core = indep_act ? np_q : paired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   out_q <= '0;
    else if (!run) out_q <= '0;
    else           out_q <= core & ~dis;
  end

  assign pwm_ah_o = out_q[0];
  assign pwm_al_o = out_q[1];
  assign pwm_bh_o = out_q[2];
  assign pwm_bl_o = out_q[3];
endmodule

// File: rtl/pwm_group_chk.sv
module pwm_group_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [3:0]       dis_i,
  input logic             indep_i,
  input logic [CNT_W-1:0] dead_i,
  input logic [CNT_W-1:0] per_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [3:0]       out_i
);
  localparam int unsigned GapW = CNT_W + 1;
  logic [GapW-1:0] gap_a_q, gap_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_a_q <= '0;
      gap_b_q <= '0;
    end else begin
      if (out_i[1:0] != 2'b00) gap_a_q <= '0;
      else if (gap_a_q != '1)  gap_a_q <= gap_a_q + GapW'(1);
      if (out_i[3:2] != 2'b00) gap_b_q <= '0;
      else if (gap_b_q != '1)  gap_b_q <= gap_b_q + GapW'(1);
    end
  end

  // R1 R8
  masked_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_i & $past({4{!run_i}} | dis_i)) == 4'b0000);

  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(indep_i) |-> !(out_i[0] && out_i[1]) && !(out_i[2] && out_i[3]));

  // R6
  gap_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_i[0]) || $rose(out_i[1])) && !$past(indep_i) && !$past(indep_i, 2)
    |-> gap_a_q >= {1'b0, $past(dead_i)});

  // R6
  gap_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_i[2]) || $rose(out_i[3])) && !$past(indep_i) && !$past(indep_i, 2)
    |-> gap_b_q >= {1'b0, $past(dead_i)});

  // R2 R11
  cnt_in_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < per_i);

  // R9
  period_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_i) |-> cnt_i == '0);
endmodule

bind pwm_group pwm_group_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run),
  .dis_i   (dis),
  .indep_i (indep_act),
  .dead_i  (dead_act),
  .per_i   (per_act),
  .cnt_i   (cnt),
  .out_i   ({pwm_bl_o, pwm_bh_o, pwm_al_o, pwm_ah_o})
);

// File: tb/tb_pwm_group.sv
module tb_pwm_group;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             ah, al, bh, bl;

  always #2 clk = ~clk;

  pwm_group #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_ah_o(ah), .pwm_al_o(al), .pwm_bh_o(bh), .pwm_bl_o(bl)
  );

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  string tag = "R1";

  // mirror of staged registers, index 0 AH 1 AL 2 BH 3 BL
  int s_ctrl = 0, s_per = 0, s_dead = 0;
  int s_duty[4] = '{0, 0, 0, 0};
  int p_ctrl = 0, p_per = 0, p_dead = 0;
  int p_duty[4] = '{0, 0, 0, 0};
  // expected-waveform state
  int a_per = 1, a_dead = 0, a_center = 0, a_indep = 0;
  int a_duty[4] = '{0, 0, 0, 0};
  int pos = 0;
  int ref_m[2] = '{0, 0};
  int run_m[2] = '{0, 0};
  int np_m[4] = '{0, 0, 0, 0};
  int exp_m = 0;
  int hi_cnt[4];
  int both_low_a, overlap_a;

  function automatic int got();
    return int'({bl, bh, al, ah});
  endfunction

  task automatic check(string t, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data[CNT_W-1:0];
    @(posedge clk); #1;
    wr_en = 1'b0;
    case (addr)
      0: s_ctrl = data & 255;
      1: s_per = data;
      2: s_dead = data;
      3: s_duty[0] = data;
      4: s_duty[2] = data;
      5: s_duty[1] = data;
      6: s_duty[3] = data;
      default: ;
    endcase
  endtask

  // R10 address map used here
  task automatic cfg(int center, int indep, int dis, int per, int dead,
                     int d_ah, int d_al, int d_bh, int d_bl);
    wr(0, (indep << 2) | (center << 1) | (dis << 4));
    wr(1, per); wr(2, dead);
    wr(3, d_ah); wr(5, d_al); wr(4, d_bh); wr(6, d_bl);
    wr(0, 1 | (indep << 2) | (center << 1) | (dis << 4));
  endtask

  task automatic count_hi(int n);
    for (int i = 0; i < 4; i++) hi_cnt[i] = 0;
    both_low_a = 0; overlap_a = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi_cnt[0] += int'(ah); hi_cnt[1] += int'(al);
      hi_cnt[2] += int'(bh); hi_cnt[3] += int'(bl);
      if (!ah && !al) both_low_a++;
      if (ah && al) overlap_a++;
    end
  endtask

  // expected waveform built from the written register values
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_m = 0; pos = 0;
      ref_m = '{0, 0}; run_m = '{0, 0}; np_m = '{0, 0, 0, 0};
    end else begin
      int en, core, cnt_v, len, dis;
      int cmp[4];
      check(tag, got(), exp_m, "outputs {bl,bh,al,ah}");
      en  = s_ctrl & 1;
      dis = (s_ctrl >> 4) & 15;
      if (en != 0 && pos == 0) begin
        a_per    = (p_per == 0) ? 1 : p_per;
        a_dead   = p_dead;
        a_center = (p_ctrl >> 1) & 1;
        a_indep  = (p_ctrl >> 2) & 1;
        for (int i = 0; i < 4; i++) a_duty[i] = p_duty[i];
      end
      core = 0;
      if (a_indep != 0) begin
        for (int i = 0; i < 4; i++) core |= np_m[i] << i;
      end else begin
        for (int c = 0; c < 2; c++) begin
          if (ref_m[c] != 0 && run_m[c] > a_dead)  core |= 1 << (2*c);
          if (ref_m[c] == 0 && run_m[c] > a_dead)  core |= 1 << (2*c+1);
        end
      end
      exp_m = (en != 0) ? (core & ~dis & 15) : 0;
      if (en == 0) begin
        pos = 0;
        ref_m = '{0, 0}; run_m = '{0, 0}; np_m = '{0, 0, 0, 0};
      end else begin
        len = (a_center != 0) ? 2 * a_per : a_per;
        cnt_v = (a_center != 0 && pos >= a_per) ? 2 * a_per - 1 - pos : pos;
        for (int i = 0; i < 4; i++) begin
          cmp[i] = (cnt_v < a_duty[i]) ? 1 : 0;
          np_m[i] = cmp[i];
        end
        for (int c = 0; c < 2; c++) begin
          if (cmp[2*c] != ref_m[c]) begin ref_m[c] = cmp[2*c]; run_m[c] = 1; end
          else run_m[c]++;
        end
        pos = (pos + 1 == len) ? 0 : pos + 1;
      end
      p_ctrl = s_ctrl; p_per = s_per; p_dead = s_dead;
      for (int i = 0; i < 4; i++) p_duty[i] = s_duty[i];
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", got(), 0, "outputs after reset");

    // R1: configured but not running
    tag = "R1";
    wr(0, 4); wr(1, 8); wr(3, 5); wr(5, 5); wr(4, 5); wr(6, 5);
    count_hi(12);
    check("R1", hi_cnt[0] + hi_cnt[1] + hi_cnt[2] + hi_cnt[3], 0, "high clocks while stopped");

    // R2 R4 R7: edge, independent
    tag = "R2";
    cfg(0, 1, 0, 8, 0, 3, 5, 0, 11);
    repeat (4) @(negedge clk);
    count_hi(8);
    check("R2", hi_cnt[0], 3, "AH high clocks edge D=3 P=8");
    check("R7", hi_cnt[1], 5, "AL independent D=5 P=8");
    check("R4", hi_cnt[2], 0, "BH duty 0");
    check("R4", hi_cnt[3], 8, "BL duty above period");

    // R8: disable AL while running
    tag = "R8";
    wr(0, 1 | 4 | (2 << 4));
    repeat (2) @(negedge clk);
    count_hi(8);
    check("R8", hi_cnt[1], 0, "AL disabled");
    check("R8", hi_cnt[0], 3, "AH unaffected by AL disable");
    check("R8", hi_cnt[3], 8, "BL unaffected by AL disable");
    wr(0, 4);

    // R3 R4: center, independent
    tag = "R3";
    cfg(1, 1, 0, 6, 0, 2, 6, 9, 0);
    repeat (4) @(negedge clk);
    count_hi(12);
    check("R3", hi_cnt[0], 4, "AH center D=2 P=6");
    check("R4", hi_cnt[1], 12, "AL center duty=P");
    check("R4", hi_cnt[2], 12, "BH center duty>P");
    check("R4", hi_cnt[3], 0, "BL center duty 0");
    wr(0, 0);

    // R5 R6: paired edge with dead time
    tag = "R5";
    cfg(0, 0, 0, 10, 2, 6, 0, 10, 0);
    repeat (12) @(negedge clk);
    count_hi(10);
    check("R5", hi_cnt[0], 4, "AH paired D=6 DT=2");
    check("R5", hi_cnt[1], 2, "AL paired complement");
    check("R5", hi_cnt[2], 10, "BH paired full duty");
    check("R5", hi_cnt[3], 0, "BL paired full duty");
    check("R6", overlap_a, 0, "A pair overlap clocks");
    check("R6", both_low_a, 4, "A pair both-low clocks");
    wr(0, 0);

    // R11: zero period
    tag = "R11";
    cfg(0, 1, 0, 0, 0, 1, 0, 1, 0);
    repeat (4) @(negedge clk);
    count_hi(5);
    check("R11", hi_cnt[0], 5, "period 0 duty 1");
    check("R11", hi_cnt[1], 0, "period 0 duty 0");
    wr(0, 0);

    // R9: duty written mid-cycle applies from next cycle
    tag = "R9";
    cfg(0, 1, 0, 16, 0, 4, 0, 0, 0);
    repeat (8) @(negedge clk);
    wr(3, 12);
    repeat (40) @(negedge clk);
    wr(0, 0);
    repeat (3) @(negedge clk);

    // random scenarios against the expected waveform
    for (int s = 0; s < 30; s++) begin
      int per, center, indep, dead, len;
      per    = 1 + int'($urandom % 16);
      center = int'($urandom % 2);
      indep  = int'($urandom % 2);
      dead   = int'($urandom % 4);
      tag    = (indep != 0) ? "R7" : ((center != 0) ? "R3" : "R5");
      cfg(center, indep, ($urandom % 4 == 0) ? int'($urandom % 16) : 0, per, dead,
          int'($urandom % (per + 3)), int'($urandom % (per + 3)),
          int'($urandom % (per + 3)), int'($urandom % (per + 3)));
      len = (center != 0) ? 2 * per : per;
      repeat (len + 3) @(negedge clk);
      if ($urandom % 2 == 1) begin
        tag = "R9";
        wr(3 + int'($urandom % 4), int'($urandom % 20));
        wr(1, 1 + int'($urandom % 16));
        if ($urandom % 2 == 1) wr(0, 1 | ((1 - indep) << 2) | (center << 1));
        repeat (40) @(negedge clk);
      end
      tag = "R8";
      wr(0, 1 | (s_ctrl & 6) | (int'($urandom % 16) << 4));
      repeat (12) @(negedge clk);
      tag = "R1";
      wr(0, s_ctrl & 6);
      repeat (4) @(negedge clk);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule